// File: doc/BRIEF.md
# Checksum-Encoded Matrix Multiplier

The block multiplies two square integer matrices and returns the product with its own checksums attached. A caller streams in the elements of A and then of B. Internally, A gains one extra row that holds the sum of each of its columns, and B gains one extra column that holds the sum of each of its rows. The encoded operands are multiplied on a mesh of multiply-accumulate cells, with one cell for each element of the result. The result is the full checksum matrix of C = A*B: the data product, a row of column sums below it, and a column of row sums to its right. A later checker can then locate and repair a single corrupted element. This block does not check the result; it only produces it.

With the default parameters the data matrices are 3x3 with 16-bit signed elements, and the result is 4x4 with 32-bit words. All arithmetic wraps modulo 2^32, so the checksum relations hold exactly even when values overflow. The compute phase takes one cycle per inner index. A single-cycle `done` pulse follows it, and then the sixteen result words stream out.

Back-pressure rules: an input word moves only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is collecting operands. An output word moves only on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` is held unchanged. The block takes no new operands until the caller has accepted the last result word.

Top module: `cmm_mult`

## Requirements
- R1: Inputs are accepted on edges where in_valid and in_ready are both high. The first 9 accepted words are A in row-major order, the next 9 are B in row-major order. in_ready drops in the cycle after the 18th word is accepted.
- R2: Result element (r,c) with r<3 and c<3 equals the sum over k of A[r][k]*B[k][c]. Each element is sign-extended from 16 bits, and the sum is taken modulo 2^32.
- R3: Result element (3,c) with c<3 equals the sum of data column c of the product, modulo 2^32.
- R4: Result element (r,3) with r<3 equals the sum of data row r of the product, modulo 2^32.
- R5: Result element (3,3) equals the sum of all nine data elements of the product, modulo 2^32.
- R6: done is high for exactly one cycle, which begins on the third clock edge after the edge that accepts the 18th input. out_valid rises in the cycle that follows.
- R7: The 16 results leave in row-major order (word index = row*4 + col). out_data and out_valid hold while out_ready is low. At most 16 words leave after each done.
- R8: in_ready stays low while out_valid or done is high. An input word presented during compute or output is not taken until the last result has been accepted.
- R9: Wrap-around is exact: operands near the 16-bit limits produce the product and checksums reduced modulo 2^32.
- R10: A synchronous reset, in any state, clears the accumulators and any partial load and returns the block to loading: in_ready=1, out_valid=0, done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 16 | Signed input matrix element |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Caller can take a result word |
| out_data | output | 32 | Result element, modulo 2^32 |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
Two events can fall in the same cycle. In the first, the caller accepts the final result word while it already holds in_valid high with the first operand of the next job. That word must stay pending until the block is back in its loading state, and it must then become A[0][0] of the new job. The bench provokes this by starting the next job's driver as soon as the previous job's operands are in, under both steady and intermittent out_ready. It judges the outcome by comparing every word of both jobs against independently computed checksum matrices. In the second, a reset lands in the same cycle as a result handshake, or in the middle of a load. That reset must win, discard the pending work, and leave a clean loading state.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2,
    ST_SEND = 2'd3
  } cmm_state_e;
endpackage

// File: rtl/cmm_cell.sv
module cmm_cell #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] acc
);
  // modulo 2^AW multiply-accumulate: low AW bits are sign-agnostic
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + a * b;
  end
endmodule

// File: rtl/cmm_encode.sv
module cmm_encode #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int KW = 2
) (
  input  logic [N*N*DW-1:0]   a_flat,
  input  logic [N*N*DW-1:0]   b_flat,
  input  logic [KW-1:0]       k,
  output logic [(N+1)*AW-1:0] a_col,
  output logic [(N+1)*AW-1:0] b_row
);
  function automatic logic [AW-1:0] sext(input logic [DW-1:0] x);
    return {{(AW-DW){x[DW-1]}}, x};
  endfunction

  // column k of the row-augmented A and row k of the column-augmented B
  always_comb begin
    logic [AW-1:0] sum_a;
    logic [AW-1:0] sum_b;
    logic [AW-1:0] ea;
    logic [AW-1:0] eb;
    sum_a = '0;
    sum_b = '0;
    a_col = '0;
    b_row = '0;
    for (int i = 0; i < N; i++) begin
      ea = sext(a_flat[(i*N + int'(k))*DW +: DW]);
      eb = sext(b_flat[(int'(k)*N + i)*DW +: DW]);
      a_col[i*AW +: AW] = ea;
      b_row[i*AW +: AW] = eb;
      sum_a = sum_a + ea;
      sum_b = sum_b + eb;
    end
    a_col[N*AW +: AW] = sum_a;
    b_row[N*AW +: AW] = sum_b;
  end
endmodule

// File: rtl/cmm_ctrl.sv
module cmm_ctrl
  import cmm_pkg::*;
#(
  parameter int N  = 3,
  parameter int LW = 5,
  parameter int KW = 2,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          load_we,
  output logic [LW-1:0] load_idx,
  output logic          acc_clr,
  output logic          acc_en,
  output logic [KW-1:0] k_idx,
  output logic          done,
  output logic          out_valid,
  output logic [OW-1:0] out_idx
);
  localparam int LOAD_LAST = 2*N*N - 1;
  localparam int OUT_LAST  = (N+1)*(N+1) - 1;

  cmm_state_e    state_q;
  logic [LW-1:0] ld_cnt;
  logic [KW-1:0] k_cnt;
  logic [OW-1:0] o_cnt;
  logic          take;
  logic          give;

  assign in_ready  = (state_q == ST_LOAD);
  assign take      = in_valid && in_ready;
  assign out_valid = (state_q == ST_SEND);
  assign give      = out_valid && out_ready;
  assign done      = (state_q == ST_DONE);
  assign acc_en    = (state_q == ST_CALC);
  assign acc_clr   = take && (ld_cnt == LW'(LOAD_LAST));
  assign load_we   = take;
  assign load_idx  = ld_cnt;
  assign k_idx     = k_cnt;
  assign out_idx   = o_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOAD;
      ld_cnt  <= '0;
      k_cnt   <= '0;
      o_cnt   <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: if (take) begin
          if (ld_cnt == LW'(LOAD_LAST)) begin
            ld_cnt  <= '0;
            state_q <= ST_CALC;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        ST_CALC: begin
          if (k_cnt == KW'(N-1)) begin
            k_cnt   <= '0;
            state_q <= ST_DONE;
          end else begin
            k_cnt <= k_cnt + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_SEND;
        ST_SEND: if (give) begin
          if (o_cnt == OW'(OUT_LAST)) begin
            o_cnt   <= '0;
            state_q <= ST_LOAD;
          end else begin
            o_cnt <= o_cnt + 1'b1;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/cmm_mult.sv
module cmm_mult #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic          done
);
  localparam int M  = N + 1;
  localparam int NN = N * N;
  localparam int LW = $clog2(2*NN);
  localparam int KW = (N > 1) ? $clog2(N) : 1;
  localparam int OW = $clog2(M*M);

  logic [NN*DW-1:0] a_q;
  logic [NN*DW-1:0] b_q;
  logic             load_we;
  logic [LW-1:0]    load_idx;
  logic             acc_clr;
  logic             acc_en;
  logic [KW-1:0]    k_idx;
  logic [OW-1:0]    out_idx;
  logic [M*AW-1:0]  a_col;
  logic [M*AW-1:0]  b_row;
  logic [AW-1:0]    acc [M*M];

  cmm_ctrl #(.N(N), .LW(LW), .KW(KW), .OW(OW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load_we   (load_we),
    .load_idx  (load_idx),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .k_idx     (k_idx),
    .done      (done),
    .out_valid (out_valid),
    .out_idx   (out_idx)
  );

  // operand store: A occupies load slots 0..NN-1, B the rest
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_we) begin
      if (int'(load_idx) < NN) a_q[int'(load_idx)*DW +: DW]        <= in_data;
      else                     b_q[(int'(load_idx) - NN)*DW +: DW] <= in_data;
    end
  end

  cmm_encode #(.N(N), .DW(DW), .AW(AW), .KW(KW)) u_enc (
    .a_flat (a_q),
    .b_flat (b_q),
    .k      (k_idx),
    .a_col  (a_col),
    .b_row  (b_row)
  );

  for (genvar r = 0; r < M; r++) begin : g_row
    for (genvar c = 0; c < M; c++) begin : g_col
      cmm_cell #(.AW(AW)) u_cell (
        .clk (clk),
        .rst (rst),
        .clr (acc_clr),
        .en  (acc_en),
        .a   (a_col[r*AW +: AW]),
        .b   (b_row[c*AW +: AW]),
        .acc (acc[r*M + c])
      );
    end
  end

  assign out_data = acc[out_idx];
endmodule

// File: rtl/cmm_mult_chk.sv
module cmm_mult_chk #(
  parameter int N  = 3,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data,
  input logic          done
);
  localparam int TOTAL = (N+1)*(N+1);
  localparam int SW    = $clog2(TOTAL + 1);

  logic [SW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst || done)                 sent <= '0;
    else if (out_valid && out_ready) sent <= sent + 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(sent) < TOTAL)); // R7

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!out_valid && !done)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && out_valid)); // R6

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !done); // R6
endmodule

bind cmm_mult cmm_mult_chk #(.N(N), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/cmm_mult_tb.sv
module cmm_mult_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int bp_mode = 0;
  int cyc = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  cmm_mult u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes the expected full checksum matrix, then streams A and B
  task automatic run_job(input int a [9], input int b [9], input string extra);
    logic [31:0] c [4][4];
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) c[i][j] = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 3; k++)
          c[i][j] = c[i][j] + 32'(a[i*3+k]) * 32'(b[k*3+j]);
    for (int j = 0; j < 3; j++) for (int i = 0; i < 3; i++) c[3][j] = c[3][j] + c[i][j];
    for (int i = 0; i < 4; i++) for (int j = 0; j < 3; j++) c[i][3] = c[i][3] + c[i][j];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        string t;
        if (i < 3 && j < 3)  t = "R2";
        else if (i == 3 && j < 3) t = "R3";
        else if (i < 3)      t = "R4";
        else                 t = "R5";
        exp_q.push_back(c[i][j]);
        tag_q.push_back({t, extra, $sformatf(" R7 idx=%0d", i*4+j)});
      end
    for (int n = 0; n < 18; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (n < 9) ? 16'(a[n]) : 16'(b[n-9]);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic [31:0] held;
  bit          hold_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      hold_prev = 1'b0;
    end else begin
      if (hold_prev) check(out_valid && out_data == held, "R7 hold", out_data, held);
      if (out_valid) check(!in_ready, "R8 in_ready while out_valid", 32'(in_ready), 32'd0);
      out_ready = (bp_mode == 0) || (cyc % 3 != 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected word", out_data, 32'd0);
        end else begin
          logic [31:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
      hold_prev = out_valid && !out_ready;
      held      = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int a1 [9] = '{1, 2, 3, 4, 5, 6, 7, 8, 9};
    int b1 [9] = '{9, 8, 7, 6, 5, 4, 3, 2, 1};
    int a2 [9] = '{-3, 7, 0, 12, -5, 2, 1, -1, 100};
    int b2 [9] = '{4, -2, 9, -8, 3, 0, 6, 1, -7};
    int a3 [9] = '{32767, -32768, 32767, -32768, 32767, 32767, 32767, 32767, -32768};
    int b3 [9] = '{-32768, 32767, 32767, 32767, 32767, -32768, 32767, -32768, 32767};
    int a4 [9] = '{5, 0, 0, 0, 5, 0, 0, 0, 5};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid && !done, "R10 reset state",
          {29'd0, in_ready, out_valid, done}, 32'h4);

    // job 1: done timing and load closure
    run_job(a1, b1, "");
    check(!in_ready, "R1 in_ready low after 18 words", 32'(in_ready), 32'd0);
    @(negedge clk);
    check(!done, "R6 done early", 32'(done), 32'd0);
    @(negedge clk);
    check(!done, "R6 done early", 32'(done), 32'd0);
    @(negedge clk);
    check(done && !out_valid, "R6 done pulse", {30'd0, done, out_valid}, 32'h2);
    @(negedge clk);
    check(!done && out_valid, "R6 done then valid", {30'd0, done, out_valid}, 32'h1);

    // job 2 overlaps job 1 output (R8), then job 3 with wrap (R9) under back-pressure
    bp_mode = 1;
    run_job(a2, b2, " R8");
    run_job(a3, b3, " R9");
    wait (exp_q.size() == 0);

    // reset in the middle of a load
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(n + 77);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #2 rst = 1'b1;
    @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid && !done, "R10 reset mid-load",
          {29'd0, in_ready, out_valid, done}, 32'h4);
    run_job(a4, b1, " R10");
    wait (exp_q.size() == 0);

    // reset while results stream out
    bp_mode = 0;
    fork
      run_job(a1, b2, "");
    join_none
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    #2 rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid && !done, "R10 reset mid-stream",
          {29'd0, in_ready, out_valid, done}, 32'h4);
    run_job(a2, b1, " R10");
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule